// File: doc/BRIEF.md
# MDIO Management Register Interface

This block lets a host reach the registers of an external Ethernet PHY over the two-wire management bus. The host sees two registers. The address register holds the PHY address, the PHY register number, a clock divider select, a direction flag and a busy flag. The data register holds the 16-bit value to send, or the value that came back.

A transaction starts with a single host write to the address register that has the busy bit set. For a write, the data register must already hold the outgoing value. The block then divides the system clock down to MDC and shifts out a clause-22 frame. On a read, it samples the PHY's reply. When the frame is over, busy drops by itself.

The host learns that a transaction has finished only by polling busy. After a read, the reply is in the data register as soon as busy reads zero. The MDIO line is driven through separate output, output-enable and input pins, so the pad can be shared with a pull-up.

Top module: `mdio_mgmt_regs`

## Requirements
- R1: After reset, both registers read zero, MDC is low and the MDIO output enable is low.
- R2: The address register is 14 bits wide, with this layout:
  - bit 0: busy
  - bit 1: direction (1 = write, 0 = read)
  - bits 3:2: divider select
  - bits 8:4: register number
  - bits 13:9: PHY address

  A host write to it with bit 0 set stores all fields and starts a transaction, and busy then reads 1.
- R3: While busy, the high phase and the low phase of MDC each last 8, 13, 21 or 31 system clocks, for divider select 0, 1, 2 or 3. That gives an MDC period of 16, 26, 42 or 62 clocks. While idle, MDC stays low.
- R4: A frame is 64 MDC periods long. Its bit 0 is sent first. The bits are:
  - bits 0–31: preamble, all ones
  - bits 32–33: start code, 0 then 1
  - bits 34–35: opcode, 1 then 0 for a read, 0 then 1 for a write
  - bits 36–40: PHY address, MSB first
  - bits 41–45: register number, MSB first
  - bits 46–47: turnaround, 1 then 0 on a write
  - bits 48–63: data, MSB first

  MDIO changes only at a falling edge of MDC, so it is stable at every rising edge. A write frame drives every bit.
- R5: On a read, the block releases MDIO (output enable low) from bit 46 to the end of the frame. It samples the line at each rising MDC edge of bits 48–63, MSB first. When busy clears, the data register holds that value.
- R6: After the 64th falling MDC edge, busy clears by itself, and all other address fields are kept. The whole transaction takes about 128 half-periods and never more than 4,100 clocks, far below a 10 ms polling budget.
- R7: While busy is set, host writes to either register are ignored. The frame being sent and both register values are unaffected.
- R8: A host write to the address register with bit 0 clear only stores the fields: no frame starts and MDC stays low. A host write to the data register while idle stores the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | Register select: 0 address, 1 data |
| host_wdata | input | 16 | Host write value (address uses bits 13:0) |
| addr_q | output | 14 | Address register contents |
| data_q | output | 16 | Data register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The embedded properties assume that the host presents at most one write per clock. They also assume that MDIO input activity matters only during the released part of a read frame. The bench meets both assumptions: it issues host writes one at a time on the falling clock edge, and its PHY model changes the MDIO input only at MDC falling edges. The bench also pokes both registers in the middle of a frame, to exercise the ignore path while the shifting is under way.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PHY_W     = 5;
    localparam int REG_W     = 5;
    localparam int SEL_W     = 2;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int HALF_W    = 5;
    localparam int FRAME_LEN = PRE_LEN + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int TA_POS    = PRE_LEN + 4 + PHY_W + REG_W;
    localparam int DATA_POS  = TA_POS + 2;
    localparam int ADDR_W    = PHY_W + REG_W + SEL_W + 2;

    typedef struct packed {
        logic [PHY_W-1:0] phy;
        logic [REG_W-1:0] regn;
        logic [SEL_W-1:0] div_sel;
        logic             wr;
        logic             busy;
    } mdio_addr_t;

    // half MDC period in system clocks for each select value
    function automatic logic [HALF_W-1:0] half_period(input logic [SEL_W-1:0] s);
        case (s)
            2'd0:    return 5'd8;
            2'd1:    return 5'd13;
            2'd2:    return 5'd21;
            default: return 5'd31;
        endcase
    endfunction

    function automatic logic [FRAME_LEN-1:0] build_frame(input mdio_addr_t a,
                                                         input logic [DATA_W-1:0] d);
        return {{PRE_LEN{1'b1}}, 2'b01, (a.wr ? 2'b01 : 2'b10), a.phy, a.regn,
                2'b10, (a.wr ? d : {DATA_W{1'b1}})};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [HALF_W-1:0] half_cnt,
    output logic              mdc,
    output logic              rise,
    output logic              fall
);
    logic [HALF_W-1:0] cnt;
    logic              mdc_q;
    logic              tick;

    assign tick = run && (cnt == half_cnt - 1'b1);
    assign rise = tick && !mdc_q;
    assign fall = tick && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt   <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // R3: clock parked low whenever no frame is running
    p_mdc_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_addr_t        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    logic [FRAME_LEN-1:0] sh;
    logic [IDX_W-1:0]     idx;
    logic                 active;
    logic                 is_wr;
    logic [DATA_W-1:0]    rsh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            idx    <= '0;
            active <= 1'b0;
            is_wr  <= 1'b0;
            rsh    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                sh     <= build_frame(addr, wdata);
                idx    <= '0;
                active <= 1'b1;
                is_wr  <= addr.wr;
            end else if (active) begin
                if (rise && !is_wr && idx >= IDX_W'(DATA_POS))
                    rsh <= {rsh[DATA_W-2:0], mdio_i};
                if (fall) begin
                    if (idx == IDX_W'(FRAME_LEN - 1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                        sh  <= {sh[FRAME_LEN-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mdio_o  = active ? sh[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = active && (is_wr || idx < IDX_W'(TA_POS));
    assign rdata   = rsh;

    // R4: line value only moves on a falling MDC edge
    p_mdio_holds_r4: assert property (@(posedge clk) disable iff (rst)
        !fall && !start |=> $stable(mdio_o));
    // R6: completion pulse lasts a single cycle
    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [15:0]       host_wdata,
    output logic [13:0]       addr_q,
    output logic [15:0]       data_q,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int MAX_BUSY = 2 * FRAME_LEN * 32 + 8;
    localparam int BUSY_W   = $clog2(MAX_BUSY + 1) + 1;

    mdio_addr_t        areg;
    mdio_addr_t        new_addr;
    logic [DATA_W-1:0] dreg;
    logic              start;
    logic              done;
    logic              rise;
    logic              fall;
    logic [DATA_W-1:0] rdata;
    logic              unused_hi;

    assign new_addr  = mdio_addr_t'(host_wdata[ADDR_W-1:0]);
    assign unused_hi = ^host_wdata[15:ADDR_W];
    assign start     = host_we && !host_sel && !areg.busy && new_addr.busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            areg <= '0;
            dreg <= '0;
        end else if (areg.busy) begin
            if (done) begin
                areg.busy <= 1'b0;
                if (!areg.wr) dreg <= rdata;
            end
        end else if (host_we) begin
            if (host_sel) dreg <= host_wdata;
            else          areg <= new_addr;
        end
    end

    mdio_clkgen #(.HALF_W(HALF_W)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .run      (areg.busy),
        .half_cnt (half_period(areg.div_sel)),
        .mdc      (mdc),
        .rise     (rise),
        .fall     (fall)
    );

    mdio_frame_eng u_eng (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .addr    (new_addr),
        .wdata   (dreg),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (done),
        .rdata   (rdata)
    );

    assign addr_q = areg;
    assign data_q = dreg;

    logic [BUSY_W-1:0] busy_len;
    always_ff @(posedge clk) begin
        if (rst || !areg.busy) busy_len <= '0;
        else                   busy_len <= busy_len + 1'b1;
    end

    // R6: a transaction always finishes within the bound
    p_busy_bounded_r6: assert property (@(posedge clk) disable iff (rst)
        busy_len <= BUSY_W'(MAX_BUSY));
    // R7: data register untouched by host writes during a frame
    p_data_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        areg.busy && host_we && host_sel ##1 areg.busy |-> $stable(dreg));
    // R7: address fields untouched by host writes during a frame
    p_addr_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        areg.busy && host_we && !host_sel |=> $stable(areg.phy) && $stable(areg.regn)
            && $stable(areg.div_sel) && $stable(areg.wr));
endmodule

// File: tb/mdio_mgmt_regs_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [13:0] addr_q;
    logic [15:0] data_q;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    always #2.5 clk = ~clk;

    mdio_mgmt_regs u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .addr_q(addr_q), .data_q(data_q),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    typedef struct {
        bit       wr;
        bit [4:0] phy;
        bit [4:0] regn;
        bit [15:0] data;
    } exp_t;
    exp_t sbq[$];

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;
    int mk = 0;
    int tot_rise = 0;
    logic [63:0] got, oev;
    logic [15:0] phy_rd = '0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // monitor: decode each 64-bit frame at MDC rising edges, compare with scoreboard
    initial begin
        got = '0;
        oev = '0;
        forever begin
            @(posedge mdc);
            got[63-mk] = mdio_o;
            oev[63-mk] = mdio_oe;
            mk++;
            tot_rise++;
            if (mk == 64) begin
                exp_t e;
                logic [63:0] ef;
                mk = 0;
                if (sbq.size() == 0) begin
                    chk("R4 unexpected frame", 64'd1, 64'd0);
                end else begin
                    e  = sbq.pop_front();
                    ef = {32'hFFFF_FFFF, 2'b01, (e.wr ? 2'b01 : 2'b10), e.phy, e.regn,
                          2'b10, e.data};
                    chk("R4 frame header", 64'(got[63:18]), 64'(ef[63:18]));
                    if (e.wr) begin
                        chk("R4 write turnaround+data", 64'(got[17:0]), 64'(ef[17:0]));
                        chk("R4 write drives all bits", oev, {64{1'b1}});
                    end else begin
                        chk("R5 read releases line", oev, {{46{1'b1}}, 18'b0});
                    end
                end
            end
        end
    end

    // PHY model: answers reads, changes the line at MDC falling edges
    initial begin
        mdio_i = 1'b1;
        forever begin
            @(negedge mdc);
            if (mk >= 36 && got[63-34] == 1'b1 && got[63-35] == 1'b0) begin
                if (mk == 47)      mdio_i = 1'b0;
                else if (mk >= 48) mdio_i = phy_rd[63-mk];
                else               mdio_i = 1'b1;
            end else begin
                mdio_i = 1'b1;
            end
        end
    end

    task automatic host_write(input logic sel, input logic [15:0] v);
        @(negedge clk);
        host_we    = 1'b1;
        host_sel   = sel;
        host_wdata = v;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    function automatic int half_of(input logic [1:0] s);
        case (s)
            2'd0: return 8;
            2'd1: return 13;
            2'd2: return 21;
            default: return 31;
        endcase
    endfunction

    task automatic xfer(input bit wr, input bit [4:0] phy, input bit [4:0] regn,
                        input bit [1:0] sel, input bit [15:0] data,
                        input bit [15:0] rd_val, input bit poke);
        exp_t e;
        logic [13:0] a;
        int cyc;
        int h;
        realtime t1, t2;
        h = half_of(sel);
        if (wr) host_write(1'b1, data);
        e.wr = wr; e.phy = phy; e.regn = regn; e.data = wr ? data : 16'h0;
        sbq.push_back(e);
        phy_rd = rd_val;
        a = {phy, regn, sel, wr, 1'b1};
        host_write(1'b0, {2'b00, a});
        chk("R2 start sets busy and fields", 64'(addr_q), 64'(a));
        if (poke) begin
            // R7: writes during the frame must be ignored
            host_write(1'b1, ~data);
            host_write(1'b0, 16'h3FFF);
            host_write(1'b0, 16'h0000);
        end
        @(posedge mdc); t1 = $realtime;
        @(posedge mdc); t2 = $realtime;
        chk("R3 mdc period", 64'(int'((t2 - t1) / 5.0)), 64'(2 * h));
        cyc = 0;
        while (addr_q[0] === 1'b1 && cyc < 10000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R6 busy clears in bound", 64'((cyc >= 128*h - 140 && cyc <= 128*h + 6) ? 1 : 0), 64'd1);
        chk("R6 fields kept after busy clears", 64'(addr_q), 64'({phy, regn, sel, wr, 1'b0}));
        if (wr) chk("R7 data register unchanged by write frame", 64'(data_q), 64'(data));
        else    chk("R5 read data captured", 64'(data_q), 64'(rd_val));
        chk("R3 mdc low when idle", 64'(mdc), 64'd0);
    endtask

    initial begin
        #(200000 * 5);
        chk("watchdog expired", 64'd1, 64'd0);
        finish_run();
    end

    initial begin
        int r0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 addr reset", 64'(addr_q), 64'd0);
        chk("R1 data reset", 64'(data_q), 64'd0);
        chk("R1 mdc reset", 64'(mdc), 64'd0);
        chk("R1 oe reset", 64'(mdio_oe), 64'd0);

        // R8 field store without busy, data store while idle
        r0 = tot_rise;
        host_write(1'b0, 16'h0A3A);
        host_write(1'b1, 16'h1234);
        repeat (100) @(negedge clk);
        chk("R8 address stored without start", 64'(addr_q), 64'h0A3A);
        chk("R8 data stored while idle", 64'(data_q), 64'h1234);
        chk("R8 no mdc activity", 64'(tot_rise - r0), 64'd0);

        xfer(1'b1, 5'h11, 5'h0A, 2'd0, 16'hBEEF, 16'h0000, 1'b0);
        xfer(1'b0, 5'h1F, 5'h01, 2'd1, 16'h0000, 16'hA5C3, 1'b0);
        xfer(1'b1, 5'h00, 5'h1F, 2'd2, 16'h0001, 16'h0000, 1'b0);
        xfer(1'b0, 5'h0A, 5'h15, 2'd3, 16'h0000, 16'hFFFE, 1'b0);
        xfer(1'b1, 5'h15, 5'h0B, 2'd0, 16'h5A96, 16'h0000, 1'b1);
        xfer(1'b0, 5'h03, 5'h10, 2'd0, 16'h0000, 16'h8001, 1'b1);

        repeat (20) @(negedge clk);
        chk("R4 every frame observed", 64'(sbq.size()), 64'd0);
        finish_run();
    end
endmodule